// File: doc/BRIEF.md
# Hypercube Dimension-Order Cut-Through Router

This block is the switching element of one node in a binary hypercube of 2^DIMS nodes. The node has one bit-serial link pair per cube dimension, plus a local injection input and a local delivery output. Every link direction is its own channel with its own valid, data, end-of-segment and ready wires. Traffic arriving on a link never competes with traffic leaving on that same link.

A message travels as one or more segments, and each segment is routed on its own. The first DIMS bits of a segment hold the destination node number, least significant bit first. An input collects the leading HDR_W bits of a segment into a header window. It then XORs the destination with the strapped node number and picks the lowest dimension in which they differ. A segment whose destination equals the node number goes to the delivery port, so a segment injected at its own destination crosses no link.

Once the output is won, the window is sent out unchanged, followed by the rest of the segment as it arrives, so forwarding begins before the tail of the segment is in. Inputs that compete for one output are served round-robin. A losing input, or one whose output is stalled, holds its ready low, so no bit is lost. An output stays with one segment until the end-of-segment bit has passed.

Top module: `hc_router`

## Requirements
- R1: While reset is asserted and after it is released, every output valid is low and every input ready is high (the inputs are waiting for a header).
- R2: The destination is taken from the first DIMS bits of a segment, with the first bit received as bit 0. No bit of a segment leaves before HDR_W bits, or its end-of-segment bit, have been accepted.
- R3: When the destination and node number differ, the segment leaves on link index d, where d is the lowest bit position in which they differ.
- R4: A segment whose destination equals the node number leaves on the delivery port, whether it arrived on a link or on the injection port.
- R5: With the output idle and downstream ready, the first forwarded bit is transferred on the third clock edge after the edge that accepts the last header-window bit, while the rest of the segment is still arriving.
- R6: Requests made to one output in the same cycle are granted round-robin. Inputs are numbered 0..DIMS-1 for the links and DIMS for injection. The search starts at input 0 after reset and afterwards at the input following the last winner on that output.
- R7: An output carries exactly the bits of one segment, in order, with end-of-segment on the last bit. It is not given to another segment until that bit has been transferred.
- R8: An input that is waiting for its output, or whose output is stalled, holds its ready low, and no bit is lost or duplicated.
- R9: Segments sent back to back on one input are routed independently and may leave on different outputs.
- R10: A segment arriving on link k is forwarded while link k's outgoing channel is stalled.
- R11: A segment shorter than HDR_W bits, or exactly HDR_W bits long, is forwarded whole, with end-of-segment on its last bit. Its input then returns to header collection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | DIMS | Number of this node (static strap) |
| lnk_vld_i | input | DIMS | Incoming link bit valid, one per dimension |
| lnk_bit_i | input | DIMS | Incoming link serial data |
| lnk_eos_i | input | DIMS | Incoming link end-of-segment marker |
| lnk_rdy_o | output | DIMS | Incoming link ready |
| inj_vld_i | input | 1 | Injection bit valid |
| inj_bit_i | input | 1 | Injection serial data |
| inj_eos_i | input | 1 | Injection end-of-segment marker |
| inj_rdy_o | output | 1 | Injection ready |
| lnk_vld_o | output | DIMS | Outgoing link bit valid |
| lnk_bit_o | output | DIMS | Outgoing link serial data |
| lnk_eos_o | output | DIMS | Outgoing link end-of-segment marker |
| lnk_rdy_i | input | DIMS | Outgoing link ready from the neighbour |
| dlv_vld_o | output | 1 | Delivery bit valid |
| dlv_bit_o | output | 1 | Delivery serial data |
| dlv_eos_o | output | 1 | Delivery end-of-segment marker |
| dlv_rdy_i | input | 1 | Delivery ready |

## Verification
Several properties are checked on every cycle:
- each header decision resolves to the lowest differing dimension, or to delivery on a full match;
- an input is never released before its window is complete;
- a grant is followed by a transfer in the next cycle;
- a short segment frees its input as soon as its final bit leaves;
- an owned output keeps its owner until release;
- no input ever holds two outputs.

Only the bench scenarios can show the rest, by comparing every output bit with a behavioural model of the expected streams. That covers:
- the round-robin order across successive contentions;
- lossless delivery under stalled or toggling downstream ready;
- the exact three-edge cut-through latency;
- independent routing of back-to-back segments;
- progress of inbound link traffic while the same link's outbound channel is blocked.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOUT = 2'd2,
    ST_BODY = 2'd3
  } port_st_e;
endpackage

// File: rtl/hcr_route.sv
module hcr_route #(
  parameter int DIMS = 4,
  parameter int PW   = $clog2(DIMS + 1)
) (
  input  logic [DIMS-1:0] dst_i,
  input  logic [DIMS-1:0] node_i,
  output logic [PW-1:0]   port_o
);
  logic [DIMS-1:0] diff;

  // lowest differing dimension wins; no difference selects delivery (index DIMS)
  always_comb begin
    diff   = dst_i ^ node_i;
    port_o = PW'(DIMS);
    for (int d = DIMS - 1; d >= 0; d--) begin
      if (diff[d]) port_o = PW'(d);
    end
  end
endmodule

// File: rtl/hcr_rr_arb.sv
module hcr_rr_arb #(
  parameter int N  = 5,
  parameter int PW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          rel_i,
  output logic          busy_o,
  output logic [PW-1:0] owner_o
);
  logic          busy_q;
  logic [PW-1:0] owner_q, ptr_q, sel;
  logic          found;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ptr_q) + i;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        found = 1'b1;
        sel   = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (!busy_q && found) begin
      busy_q  <= 1'b1;
      owner_q <= sel;
      ptr_q   <= (sel == PW'(N - 1)) ? '0 : sel + PW'(1);
    end else if (busy_q && rel_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  // R7: ownership only ends with a release
  a_r7_owner_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !rel_i) |=> (busy_q && $stable(owner_q)));
endmodule

// File: rtl/hcr_in_port.sv
module hcr_in_port
  import hcr_pkg::*;
#(
  parameter int DIMS  = 4,
  parameter int HDR_W = 36,
  parameter int PW    = $clog2(DIMS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIMS-1:0] node_i,
  input  logic            in_vld_i,
  input  logic            in_bit_i,
  input  logic            in_eos_i,
  output logic            in_rdy_o,
  output logic            req_o,
  output logic [PW-1:0]   route_o,
  input  logic            gnt_i,
  output logic            out_vld_o,
  output logic            out_bit_o,
  output logic            out_eos_o,
  input  logic            out_rdy_i,
  output logic            rel_o
);
  localparam int CW = $clog2(HDR_W + 1);
  localparam int IW = $clog2(HDR_W);

  port_st_e         st_q;
  logic [HDR_W-1:0] hdr_q;
  logic [CW-1:0]    cnt_q;
  logic             short_q;
  logic [PW-1:0]    route_q, route_w;

  hcr_route #(.DIMS(DIMS), .PW(PW)) u_route (
    .dst_i  (hdr_q[DIMS-1:0]),
    .node_i (node_i),
    .port_o (route_w)
  );

  assign route_o = (st_q == ST_REQ) ? route_w : route_q;

  always_comb begin
    in_rdy_o  = 1'b0;
    req_o     = 1'b0;
    out_vld_o = 1'b0;
    out_bit_o = hdr_q[0];
    out_eos_o = 1'b0;
    rel_o     = 1'b0;
    unique case (st_q)
      ST_HDR:  in_rdy_o = 1'b1;
      ST_REQ:  req_o = 1'b1;
      ST_HOUT: begin
        out_vld_o = 1'b1;
        out_eos_o = short_q && (cnt_q == CW'(1));
        rel_o     = out_eos_o && out_rdy_i;
      end
      ST_BODY: begin
        // cut-through: tail streams straight from input to output
        out_vld_o = in_vld_i;
        out_bit_o = in_bit_i;
        out_eos_o = in_eos_i;
        in_rdy_o  = out_rdy_i;
        rel_o     = in_vld_i && in_eos_i && out_rdy_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HDR;
      hdr_q   <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
      route_q <= '0;
    end else begin
      unique case (st_q)
        ST_HDR: if (in_vld_i) begin
          hdr_q[cnt_q[IW-1:0]] <= in_bit_i;
          cnt_q                <= cnt_q + CW'(1);
          if (in_eos_i || cnt_q == CW'(HDR_W - 1)) begin
            st_q    <= ST_REQ;
            short_q <= in_eos_i;
          end
        end
        ST_REQ: begin
          route_q <= route_w;
          if (gnt_i) st_q <= ST_HOUT;
        end
        ST_HOUT: if (out_rdy_i) begin
          hdr_q <= hdr_q >> 1;
          cnt_q <= cnt_q - CW'(1);
          if (cnt_q == CW'(1)) begin
            if (short_q) begin
              st_q    <= ST_HDR;
              hdr_q   <= '0;
              short_q <= 1'b0;
            end else begin
              st_q <= ST_BODY;
            end
          end
        end
        ST_BODY: if (in_vld_i && in_eos_i && out_rdy_i) begin
          st_q  <= ST_HDR;
          hdr_q <= '0;
          cnt_q <= '0;
        end
        default: st_q <= ST_HDR;
      endcase
    end
  end

  logic [DIMS-1:0] low_mask;
  assign low_mask = (DIMS'(1) << route_w) - DIMS'(1);

  a_r2_window_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ) |-> ((cnt_q == CW'(HDR_W)) || short_q));

  a_r3_lowest_dim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && route_w != PW'(DIMS)) |->
      ((hdr_q[route_w] != node_i[route_w]) &&
       (((hdr_q[DIMS-1:0] ^ node_i) & low_mask) == '0)));

  a_r4_local_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && route_w == PW'(DIMS)) |-> (hdr_q[DIMS-1:0] == node_i));

  a_r5_send_after_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && gnt_i) |=> (st_q == ST_HOUT && out_vld_o));

  a_r11_short_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOUT && short_q && cnt_q == CW'(1) && out_rdy_i) |=>
      (st_q == ST_HDR && in_rdy_o));
endmodule

// File: rtl/hc_router.sv
module hc_router #(
  parameter int DIMS  = 4,
  parameter int HDR_W = 36
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIMS-1:0] node_id_i,
  input  logic [DIMS-1:0] lnk_vld_i,
  input  logic [DIMS-1:0] lnk_bit_i,
  input  logic [DIMS-1:0] lnk_eos_i,
  output logic [DIMS-1:0] lnk_rdy_o,
  input  logic            inj_vld_i,
  input  logic            inj_bit_i,
  input  logic            inj_eos_i,
  output logic            inj_rdy_o,
  output logic [DIMS-1:0] lnk_vld_o,
  output logic [DIMS-1:0] lnk_bit_o,
  output logic [DIMS-1:0] lnk_eos_o,
  input  logic [DIMS-1:0] lnk_rdy_i,
  output logic            dlv_vld_o,
  output logic            dlv_bit_o,
  output logic            dlv_eos_o,
  input  logic            dlv_rdy_i
);
  localparam int NP = DIMS + 1;
  localparam int PW = $clog2(NP);

  // index DIMS is injection on the input side and delivery on the output side
  logic [NP-1:0] i_vld, i_bit, i_eos, i_rdy;
  logic [NP-1:0] ip_req, ip_gnt, ip_ovld, ip_obit, ip_oeos, ip_ordy, ip_rel;
  logic [PW-1:0] ip_route [NP];
  logic [NP-1:0] a_busy, a_rel;
  logic [PW-1:0] a_owner [NP];
  logic [NP-1:0] a_req [NP];
  logic [NP-1:0] o_vld, o_bit, o_eos, o_rdy;

  assign i_vld = {inj_vld_i, lnk_vld_i};
  assign i_bit = {inj_bit_i, lnk_bit_i};
  assign i_eos = {inj_eos_i, lnk_eos_i};
  assign {inj_rdy_o, lnk_rdy_o} = i_rdy;
  assign o_rdy = {dlv_rdy_i, lnk_rdy_i};
  assign {dlv_vld_o, lnk_vld_o} = o_vld;
  assign {dlv_bit_o, lnk_bit_o} = o_bit;
  assign {dlv_eos_o, lnk_eos_o} = o_eos;

  for (genvar p = 0; p < NP; p++) begin : g_in
    hcr_in_port #(.DIMS(DIMS), .HDR_W(HDR_W), .PW(PW)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .node_i    (node_id_i),
      .in_vld_i  (i_vld[p]),
      .in_bit_i  (i_bit[p]),
      .in_eos_i  (i_eos[p]),
      .in_rdy_o  (i_rdy[p]),
      .req_o     (ip_req[p]),
      .route_o   (ip_route[p]),
      .gnt_i     (ip_gnt[p]),
      .out_vld_o (ip_ovld[p]),
      .out_bit_o (ip_obit[p]),
      .out_eos_o (ip_oeos[p]),
      .out_rdy_i (ip_ordy[p]),
      .rel_o     (ip_rel[p])
    );
    assign ip_gnt[p]  = a_busy[ip_route[p]] && (a_owner[ip_route[p]] == PW'(p));
    assign ip_ordy[p] = o_rdy[ip_route[p]];
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    for (genvar p = 0; p < NP; p++) begin : g_req
      assign a_req[o][p] = ip_req[p] && (ip_route[p] == PW'(o));
    end

    hcr_rr_arb #(.N(NP), .PW(PW)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (a_req[o]),
      .rel_i   (a_rel[o]),
      .busy_o  (a_busy[o]),
      .owner_o (a_owner[o])
    );

    assign a_rel[o] = a_busy[o] && ip_rel[a_owner[o]];
    assign o_vld[o] = a_busy[o] && ip_ovld[a_owner[o]];
    assign o_bit[o] = a_busy[o] && ip_obit[a_owner[o]];
    assign o_eos[o] = a_busy[o] && ip_oeos[a_owner[o]];
  end

  logic [NP-1:0] own_m [NP];
  for (genvar p = 0; p < NP; p++) begin : g_chk
    for (genvar o = 0; o < NP; o++) begin : g_own
      assign own_m[p][o] = a_busy[o] && (a_owner[o] == PW'(p));
    end
    // R7: one segment never holds two outputs
    a_r7_one_output_per_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(own_m[p]));
  end
endmodule

// File: tb/hc_router_tb.sv
`timescale 1ns/100ps
module hc_router_tb;
  localparam int DIMS  = 4;
  localparam int HDR_W = 36;
  localparam int NP    = DIMS + 1;
  localparam int MAXL  = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [DIMS-1:0] node_id;
  logic [NP-1:0]   drv_vld, drv_bit, drv_eos, snk_rdy;
  logic [NP-1:0]   src_rdy, mon_vld, mon_bit, mon_eos;
  logic [DIMS-1:0] lnk_rdy_o, lnk_vld_o, lnk_bit_o, lnk_eos_o;
  logic            inj_rdy_o, dlv_vld_o, dlv_bit_o, dlv_eos_o;

  hc_router #(.DIMS(DIMS), .HDR_W(HDR_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .node_id_i (node_id),
    .lnk_vld_i (drv_vld[DIMS-1:0]),
    .lnk_bit_i (drv_bit[DIMS-1:0]),
    .lnk_eos_i (drv_eos[DIMS-1:0]),
    .lnk_rdy_o (lnk_rdy_o),
    .inj_vld_i (drv_vld[DIMS]),
    .inj_bit_i (drv_bit[DIMS]),
    .inj_eos_i (drv_eos[DIMS]),
    .inj_rdy_o (inj_rdy_o),
    .lnk_vld_o (lnk_vld_o),
    .lnk_bit_o (lnk_bit_o),
    .lnk_eos_o (lnk_eos_o),
    .lnk_rdy_i (snk_rdy[DIMS-1:0]),
    .dlv_vld_o (dlv_vld_o),
    .dlv_bit_o (dlv_bit_o),
    .dlv_eos_o (dlv_eos_o),
    .dlv_rdy_i (snk_rdy[DIMS])
  );

  assign src_rdy = {inj_rdy_o, lnk_rdy_o};
  assign mon_vld = {dlv_vld_o, lnk_vld_o};
  assign mon_bit = {dlv_bit_o, lnk_bit_o};
  assign mon_eos = {dlv_eos_o, lnk_eos_o};

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string cur_req = "R1";
  logic [1:0] exp_q [NP][$];   // {eos, bit}
  int hdr_cyc   [NP];
  int eos_cyc   [NP];
  int first_out [NP];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: lowest differing dimension, else delivery
  function automatic int route_of(input logic [DIMS-1:0] dst);
    for (int d = 0; d < DIMS; d++) if (dst[d] != node_id[d]) return d;
    return DIMS;
  endfunction

  function automatic logic [MAXL-1:0] mk_seg(input logic [DIMS-1:0] dst, input int len);
    logic [MAXL-1:0] m;
    for (int w = 0; w < MAXL / 32; w++) m[w*32 +: 32] = $urandom;
    m[DIMS-1:0] = dst;
    for (int i = 0; i < MAXL; i++) if (i >= len) m[i] = 1'b0;
    return m;
  endfunction

  task automatic expect_seg(input logic [MAXL-1:0] m, input int len);
    int o;
    o = route_of(m[DIMS-1:0]);
    for (int i = 0; i < len; i++) exp_q[o].push_back({(i == len - 1), m[i]});
  endtask

  task automatic send_seg(input int p, input logic [MAXL-1:0] m, input int len);
    int i;
    i = 0;
    while (i < len) begin
      @(negedge clk);
      drv_vld[p] = 1'b1;
      drv_bit[p] = m[i];
      drv_eos[p] = (i == len - 1);
      #1;
      if (src_rdy[p]) begin
        if (i == HDR_W - 1) hdr_cyc[p] = cyc + 1;
        if (i == len - 1) eos_cyc[p] = cyc + 1;
        i++;
      end
    end
    @(posedge clk);
    #1;
    drv_vld[p] = 1'b0;
    drv_eos[p] = 1'b0;
  endtask

  function automatic int pending();
    int n;
    n = 0;
    for (int o = 0; o < NP; o++) n += exp_q[o].size();
    return n;
  endfunction

  task automatic drain(input string req);
    int n;
    n = 0;
    while (pending() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(pending() == 0, req, "bits still expected after drain", pending(), 0);
  endtask

  task automatic do_reset(input logic [DIMS-1:0] id);
    @(negedge clk);
    rst_ni  = 1'b0;
    node_id = id;
    drv_vld = '0;
    drv_bit = '0;
    drv_eos = '0;
    snk_rdy = '1;
    for (int o = 0; o < NP; o++) exp_q[o].delete();
    repeat (3) @(negedge clk);
    #1;
    chk(mon_vld == '0, "R1", "output valid during reset", int'(mon_vld), 0);
    chk(src_rdy == '1, "R1", "input ready during reset", int'(src_rdy), (1 << NP) - 1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(mon_vld == '0, "R1", "output valid after reset", int'(mon_vld), 0);
    chk(src_rdy == '1, "R1", "input ready after reset", int'(src_rdy), (1 << NP) - 1);
  endtask

  // per-clock comparison of every output transfer against the model
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int o = 0; o < NP; o++) begin
        if (mon_vld[o] && snk_rdy[o]) begin
          logic [1:0] e;
          if (first_out[o] < 0) first_out[o] = cyc + 1;
          if (exp_q[o].size() == 0) begin
            chk(1'b0, cur_req, $sformatf("unexpected bit on output %0d", o), 1, 0);
          end else begin
            e = exp_q[o].pop_front();
            chk(mon_bit[o] == e[0], cur_req, $sformatf("data bit on output %0d", o), int'(mon_bit[o]), int'(e[0]));
            chk(mon_eos[o] == e[1], cur_req, $sformatf("eos on output %0d", o), int'(mon_eos[o]), int'(e[1]));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, got %0d pending bits expected 0", pending());
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [MAXL-1:0] ma, mb, mc, md;
    for (int o = 0; o < NP; o++) first_out[o] = -1;
    node_id = 4'b0101;
    drv_vld = '0; drv_bit = '0; drv_eos = '0; snk_rdy = '1;

    // R1
    cur_req = "R1";
    do_reset(4'b0101);

    // R3: multi-bit differences, lowest differing dimension picks link d
    cur_req = "R3";
    for (int d = 0; d < DIMS; d++) begin
      ma = mk_seg(node_id ^ DIMS'((4'hF << d) & 4'hF), 60);
      expect_seg(ma, 60);
      send_seg(DIMS, ma, 60);
    end
    drain("R3");

    // R4: matching destination goes to delivery from injection and from a link
    cur_req = "R4";
    ma = mk_seg(node_id, 50);
    expect_seg(ma, 50);
    send_seg(DIMS, ma, 50);
    mb = mk_seg(node_id, 70);
    expect_seg(mb, 70);
    send_seg(2, mb, 70);
    drain("R4");

    // R5 / R2: cut-through timing on a long segment
    cur_req = "R5";
    for (int o = 0; o < NP; o++) first_out[o] = -1;
    ma = mk_seg(node_id ^ 4'b0010, 200);
    expect_seg(ma, 200);
    send_seg(DIMS, ma, 200);
    drain("R5");
    chk(first_out[1] - hdr_cyc[DIMS] == 3, "R5", "edges from header capture to first output", first_out[1] - hdr_cyc[DIMS], 3);
    chk(first_out[1] < eos_cyc[DIMS], "R5", "first output before input tail", first_out[1], eos_cyc[DIMS]);
    chk(first_out[1] > hdr_cyc[DIMS], "R2", "output started before header complete", first_out[1], hdr_cyc[DIMS] + 3);

    // R11: short segment and one of exactly HDR_W bits
    cur_req = "R11";
    ma = mk_seg(node_id ^ 4'b1000, 10);
    expect_seg(ma, 10);
    send_seg(DIMS, ma, 10);
    mb = mk_seg(node_id ^ 4'b1100, HDR_W);
    expect_seg(mb, HDR_W);
    send_seg(DIMS, mb, HDR_W);
    drain("R11");
    #1;
    chk(src_rdy[DIMS] == 1'b1, "R11", "injection ready after short segments", int'(src_rdy[DIMS]), 1);

    // R9: back-to-back segments on link 3 to different outputs
    cur_req = "R9";
    ma = mk_seg(node_id, 45);
    mb = mk_seg(node_id ^ 4'b0001, 55);
    expect_seg(ma, 45);
    expect_seg(mb, 55);
    send_seg(3, ma, 45);
    send_seg(3, mb, 55);
    drain("R9");

    // R10: inbound on link 0 proceeds while outgoing link 0 is blocked
    cur_req = "R10";
    snk_rdy[0] = 1'b0;
    ma = mk_seg(node_id ^ 4'b0001, 80);
    mb = mk_seg(node_id, 80);
    expect_seg(ma, 80);
    expect_seg(mb, 80);
    fork
      send_seg(DIMS, ma, 80);
    join_none
    send_seg(0, mb, 80);
    repeat (5) @(negedge clk);
    chk(exp_q[DIMS].size() == 0, "R10", "delivery bits left while link 0 out stalled", exp_q[DIMS].size(), 0);
    chk(exp_q[0].size() == 80, "R10", "stalled link 0 output bits kept", exp_q[0].size(), 80);
    chk(src_rdy[DIMS] == 1'b0, "R8", "stalled injection ready", int'(src_rdy[DIMS]), 0);
    snk_rdy[0] = 1'b1;
    wait fork;
    drain("R10");

    // R8: toggling downstream ready on delivery
    cur_req = "R8";
    ma = mk_seg(node_id, 120);
    expect_seg(ma, 120);
    fork
      send_seg(1, ma, 120);
      begin
        logic [7:0] lf;
        lf = 8'hA5;
        repeat (300) begin
          @(negedge clk);
          lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
          snk_rdy[DIMS] = lf[0];
        end
        snk_rdy[DIMS] = 1'b1;
      end
    join
    drain("R8");

    // R6 / R7: contention on delivery, round-robin order
    cur_req = "R6";
    do_reset(4'b0000);
    ma = mk_seg(4'b0000, 120);
    mb = mk_seg(4'b0000, 100);
    expect_seg(ma, 120);   // input 1 wins first from start pointer 0
    expect_seg(mb, 100);
    fork
      send_seg(1, ma, 120);
      send_seg(2, mb, 100);
      begin
        repeat (HDR_W + 45) @(negedge clk);
        #1;
        chk(src_rdy[2] == 1'b0, "R8", "losing input 2 ready", int'(src_rdy[2]), 0);
        chk(src_rdy[1] == 1'b1, "R7", "winning input 1 ready", int'(src_rdy[1]), 1);
      end
    join
    drain("R7");
    mc = mk_seg(4'b0000, 90);
    md = mk_seg(4'b0000, 90);
    expect_seg(mc, 90);    // pointer now after input 2, so input 3 beats input 1
    expect_seg(md, 90);
    fork
      send_seg(3, mc, 90);
      send_seg(1, md, 90);
    join
    drain("R6");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule